// File: doc/BRIEF.md
# Time-Shared Halfband Decimator Cascade

This block reduces the sample rate of a 16-bit signed stream by 64. It runs six decimate-by-two halfband stages one after another. All six share a single multiply-accumulate datapath that is reused over time. Each stage keeps its own circular history buffer and its own set of programmable coefficients. Stages 0 to 4 are 19-tap filters. Stage 5, the last and slowest stage, is a 51-tap filter. Every stage uses halfband symmetry, so each multiply is applied to a pre-added pair of samples, plus one multiply for the centre term.

An input sample arrives with a one-cycle strobe and is held as pending work for stage 0. A fixed-priority scheduler always serves the lowest-numbered pending stage first. On every input, a stage stores the sample in its history buffer. On every second input, it also runs one multiply-accumulate per symmetric pair and one for the centre tap. It then rounds and saturates the sum and passes the result on as pending work for the next stage. Results from the last stage leave on the output port with a one-cycle strobe. Coefficients are loaded through a plain write port that takes a stage number, a coefficient slot and a value.

Top module: `halfband_chain`

## Requirements
- R1: After reset, `out_valid` is low, every history buffer holds zeros and every coefficient is zero.
- R2: Exactly one output is produced for every 64 accepted inputs. The first output follows the 64th input.
- R3: A stage with P pairs and length N computes the sum of c[j]·(x[n−2j] + x[n−(N−1−2j)]) for slots j = 0..P−1, plus c[P]·x[n−(N−1)/2]. Here x[n] is the sample that stage has just received. A stage computes only on its 2nd, 4th, 6th, … input.
- R4: Stages 0–4 have N = 19 (P = 5, slots 0..5). Stage 5 has N = 51 (P = 13, slots 0..13).
- R5: Coefficients are signed Q1.15. The sum is rounded by adding 2^14 and then shifting right arithmetically by 15.
- R6: The rounded value is clamped to the range [−32768, 32767] before it goes to the next stage or to the output.
- R7: A write with `coef_we` high stores `coef_data` into slot `coef_tap` of stage `coef_stage`. A write to a stage above 5, or to a slot above that stage's P, changes nothing.
- R8: A coefficient write is used by every computation of that stage that starts after the write. History buffers keep their contents across coefficient writes.
- R9: Pending work is served in order, earliest stage first. With inputs spaced at least 16 cycles apart, no pending sample is overwritten before it is consumed.
- R10: `out_valid` is a single-cycle pulse and never stays high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_stage | input | 3 | Target stage, 0..5 |
| coef_tap | input | 4 | Coefficient slot (pair index, or P for centre) |
| coef_data | input | 16 | Signed Q1.15 coefficient |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Signed decimated output sample |

## Verification
A wrong internal state has visible effects at the ports:
- A wrong history address, a stale write pointer or a lost phase toggle puts a wrong value in the next result of that stage. Because the stages are cascaded, the error reaches `out_data` within the following 64 inputs.
- A lost or overwritten pending sample changes the output count against the input count.
- Coefficient mis-addressing shows up as a mismatch on the first output computed after the write.

The bench keeps an arithmetic model of all six stages and compares every output in order. It uses zero, random and saturating coefficient sets.

// File: rtl/halfband_chain.sv
module halfband_chain #(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int AW       = 40,
  parameter int NST      = 6,
  parameter int NS_TAPS  = 19,
  parameter int NL_TAPS  = 51
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic signed [DW-1:0]          in_data,
  input  logic                          coef_we,
  input  logic [$clog2(NST)-1:0]        coef_stage,
  input  logic [$clog2((NL_TAPS+1)/4+1)-1:0] coef_tap,
  input  logic signed [CW-1:0]          coef_data,
  output logic                          out_valid,
  output logic signed [DW-1:0]          out_data
);
  localparam int MAXP = (NL_TAPS + 1) / 4 + 1;
  localparam int MEM  = (NST - 1) * NS_TAPS + NL_TAPS;
  localparam int MAW  = $clog2(MEM);
  localparam int CAW  = $clog2(NST * MAXP);
  localparam int SW   = $clog2(NST);
  localparam int KW   = $clog2(MAXP);
  localparam int PW   = $clog2(NL_TAPS);
  localparam int PRW  = DW + 1 + CW;
  localparam int FRAC = CW - 1;
  localparam logic signed [AW-1:0] HALF = AW'(1) << (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = AW'((1 << (DW - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  function automatic int ntaps(input logic [SW-1:0] s);
    return (int'(s) == NST - 1) ? NL_TAPS : NS_TAPS;
  endfunction
  function automatic int npairs(input logic [SW-1:0] s);
    return (ntaps(s) + 1) / 4;
  endfunction

  logic signed [DW-1:0] dl [MEM];
  logic signed [CW-1:0] cf [NST*MAXP];
  logic signed [DW-1:0] pend_d [NST];
  logic [PW-1:0]        wptr [NST];
  logic [NST-1:0]       pend_v, phase;
  logic [SW-1:0]        cur, sel;
  logic [KW-1:0]        k;
  logic [PW-1:0]        newest;
  logic                 run, last;
  logic signed [AW-1:0] acc, acc_nx, rnd, shr;
  logic [MAW-1:0]       adr_a, adr_b;
  logic [CAW-1:0]       adr_c;
  logic signed [DW:0]   psum;
  logic signed [PRW-1:0] prod;
  logic signed [DW-1:0] xa, xb, res;

  always_comb begin
    sel = '0;
    for (int i = NST - 1; i >= 0; i--) if (pend_v[i]) sel = SW'(i);
  end

  always_comb begin
    int n, p, da, db, ta, tb;
    n = ntaps(cur);
    p = npairs(cur);
    last = (int'(k) == p);
    da = last ? (n - 1) / 2 : 2 * int'(k);
    db = n - 1 - 2 * int'(k);
    ta = int'(newest) - da; if (ta < 0) ta += n;
    tb = int'(newest) - db; if (tb < 0) tb += n;
    if (tb >= n) tb -= n;
    adr_a = MAW'(int'(cur) * NS_TAPS + ta);
    adr_b = MAW'(int'(cur) * NS_TAPS + tb);
    adr_c = CAW'(int'(cur) * MAXP + int'(k));
  end

  assign xa     = dl[adr_a];
  assign xb     = last ? '0 : dl[adr_b];
  assign psum   = {xa[DW-1], xa} + {xb[DW-1], xb};
  assign prod   = PRW'(psum) * PRW'(cf[adr_c]);
  assign acc_nx = acc + {{(AW-PRW){prod[PRW-1]}}, prod};
  assign rnd    = acc_nx + HALF;
  assign shr    = rnd >>> FRAC;
  assign res    = (shr > MAXV) ? MAXV[DW-1:0] : (shr < MINV) ? MINV[DW-1:0] : shr[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM; i++) dl[i] <= '0;
      for (int i = 0; i < NST*MAXP; i++) cf[i] <= '0;
      for (int i = 0; i < NST; i++) begin pend_d[i] <= '0; wptr[i] <= '0; end
      pend_v    <= '0;
      phase     <= '0;
      cur       <= '0;
      k         <= '0;
      newest    <= '0;
      run       <= 1'b0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (coef_we && int'(coef_stage) < NST && int'(coef_tap) <= npairs(coef_stage))
        cf[CAW'(int'(coef_stage) * MAXP + int'(coef_tap))] <= coef_data;
      if (!run && |pend_v) begin
        dl[MAW'(int'(sel) * NS_TAPS + int'(wptr[sel]))] <= pend_d[sel];
        newest       <= wptr[sel];
        wptr[sel]    <= (int'(wptr[sel]) == ntaps(sel) - 1) ? '0 : wptr[sel] + 1'b1;
        phase[sel]   <= ~phase[sel];
        pend_v[sel]  <= 1'b0;
        if (phase[sel]) begin
          run <= 1'b1;
          cur <= sel;
          k   <= '0;
          acc <= '0;
        end
      end else if (run) begin
        acc <= acc_nx;
        k   <= k + 1'b1;
        if (last) begin
          run <= 1'b0;
          if (int'(cur) == NST - 1) begin
            out_valid <= 1'b1;
            out_data  <= res;
          end else begin
            pend_v[cur + 1'b1] <= 1'b1;
            pend_d[cur + 1'b1] <= res;
          end
        end
      end
      if (in_valid) begin
        pend_v[0] <= 1'b1;
        pend_d[0] <= in_data;
      end
    end
  end

  p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !pend_v[0]);
  p_chain_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last && int'(cur) < NST - 1) |-> !pend_v[cur + 1'b1]);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_out_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(run && int'(cur) == NST - 1));
  p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> int'(k) <= npairs(cur));
  for (genvar g = 0; g < NST; g++) begin : g_ptr
    p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wptr[g]) < ntaps(SW'(g)));
  end
endmodule

// File: tb/halfband_chain_test.sv
module halfband_chain_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, coef_we = 1'b0;
  logic signed [15:0] in_data = '0, coef_data = '0, out_data;
  logic [2:0] coef_stage = '0;
  logic [3:0] coef_tap = '0;
  logic out_valid;

  halfband_chain uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_stage(coef_stage), .coef_tap(coef_tap), .coef_data(coef_data),
    .out_valid(out_valid), .out_data(out_data));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, in_cnt = 0, out_cnt = 0, cyc = 0;
  int hist [6][51];
  int ph [6];
  int cm [6][14];
  int exp_q [$];
  string tag = "R1";
  logic prev_ov = 1'b0;
  bit first_seen = 1'b0, done = 1'b0;

  function automatic int ntp(int s); return s == 5 ? 51 : 19; endfunction
  function automatic int npr(int s); return (ntp(s) + 1) / 4; endfunction

  task automatic check(string req, int got, int expv);
    checks++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic model_push(int x);
    int v = x;
    for (int s = 0; s < 6; s++) begin
      int n = ntp(s), p = npr(s);
      longint acc, r;
      for (int i = 50; i > 0; i--) hist[s][i] = hist[s][i-1];
      hist[s][0] = v;
      if (ph[s] == 0) begin ph[s] = 1; return; end
      ph[s] = 0;
      acc = 0;
      for (int j = 0; j < p; j++)
        acc += longint'(cm[s][j]) * longint'(hist[s][2*j] + hist[s][n-1-2*j]);
      acc += longint'(cm[s][p]) * longint'(hist[s][(n-1)/2]);
      r = (acc + 16384) >>> 15;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      v = int'(r);
    end
    exp_q.push_back(v);
  endtask

  task automatic send(int x, int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(x);
    model_push(x);
    in_cnt++;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  task automatic wcoef(int s, int t, int v);
    @(negedge clk);
    coef_we = 1'b1; coef_stage = 3'(s); coef_tap = 4'(t); coef_data = 16'(v);
    if (s < 6 && t <= npr(s)) cm[s][t] = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        int e;
        // R10: no two-cycle output strobe
        check("R10", int'(prev_ov), 0);
        if (!first_seen) begin
          first_seen = 1'b1;
          // R2: first output follows the 64th input
          check("R2", int'(in_cnt >= 64 && in_cnt <= 67), 1);
        end
        out_cnt++;
        if (exp_q.size() == 0) check({tag, " extra output"}, 1, 0);
        else begin
          e = exp_q.pop_front();
          check(tag, int'(out_data), e);
        end
      end
      prev_ov = out_valid;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    for (int s = 0; s < 6; s++) begin
      ph[s] = 0;
      for (int i = 0; i < 51; i++) hist[s][i] = 0;
      for (int j = 0; j < 14; j++) cm[s][j] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(out_valid), 0);
    rst_n = 1'b1;
    // R1: zero coefficients give zero output regardless of input
    tag = "R1";
    for (int i = 0; i < 128; i++) send(int'($urandom_range(0, 65535)) - 32768, 20);
    repeat (150) @(negedge clk);

    // R3 R4 R7: typical halfband-like set plus writes that must be ignored
    for (int s = 0; s < 6; s++) begin
      for (int j = 0; j < npr(s); j++) wcoef(s, j, int'($urandom_range(0, 6000)) - 3000);
      wcoef(s, npr(s), 16384);
    end
    wcoef(0, 9, 12345);
    wcoef(3, 6, -9999);
    wcoef(6, 0, 7777);
    wcoef(7, 2, -7777);
    tag = "R3,R4,R7";
    for (int i = 0; i < 1024; i++) send(int'($urandom_range(0, 40000)) - 20000, 20);
    repeat (150) @(negedge clk);

    // R5 R6 R8: large coefficients, full-scale input, history retained
    for (int s = 0; s < 6; s++)
      for (int j = 0; j <= npr(s); j++) wcoef(s, j, (j % 2 == 0) ? 32767 : 30000);
    tag = "R5,R6,R8";
    for (int i = 0; i < 512; i++) send((i % 3 == 0) ? -32768 : 32767, 20);
    repeat (150) @(negedge clk);

    // R9 R5: fastest permitted input spacing with a random full-range set
    for (int s = 0; s < 6; s++)
      for (int j = 0; j <= npr(s); j++) wcoef(s, j, int'($urandom_range(0, 65535)) - 32768);
    tag = "R9,R5";
    for (int i = 0; i < 1024; i++) send(int'($urandom_range(0, 65535)) - 32768, 16);
    repeat (200) @(negedge clk);

    // R2: one output per 64 inputs overall
    check("R2", out_cnt, in_cnt / 64);
    check("R2", exp_q.size(), 0);
    finish_run();
  end
endmodule